// File: doc/BRIEF.md
# Dual-Rail Voltage-Code Trim Target Controller

This block turns a 4-bit voltage-identification code, set on a bank of switches, into the target word for a closed-loop trim loop. It serves two supply rails, a higher-voltage rail and a lower-voltage rail. Each rail has its own code switches and its own active-low push-button. Both rails read one shared code-to-target table, and a round-robin arbiter grants the table to one rail per cycle.

A momentary press on a rail's button latches that rail's switches. The latched code is then looked up and applied. A zero code shuts the rail down. Any other code enables the rail and loads the new target. A code outside the rail's usable range is still applied, but it raises that rail's range-warning flag. A free-running heartbeat output shows that the logic is clocked and out of reset.

The block has no streaming data path. Every pin is a plain level control or status signal, so no valid/ready handshake and no back-pressure apply. An output holds its value until the next press on that rail is applied.

Top module: `vid_trim_ctrl`

## Requirements
- R1: After a code is applied, a zero code drives the rail's enable low, its LED low and its target to 0. A nonzero code drives the enable high and the LED high. The LED always equals the enable.
- R2: The target word for codes 0 to 15 is 0, 570, 580, 590, 595, 600, 605, 610, 620, 630, 1200, 1225, 1250, 1275, 1300, 1310. The same code gives the same target on either rail.
- R3: Switch input bit 0 (switch 1) is the least significant bit of the code. For example, sw = 4'b1000 is code 8 and gives target 620.
- R4: A rail's outputs change only when a press is detected on that rail's button. A press is the falling edge of the debounced, active-low button. Switch changes without a press are ignored, and the release of the button latches nothing.
- R5: After reset, both enables, both LEDs, both targets, both warning flags and the heartbeat are 0.
- R6: The heartbeat toggles every HB_HALF_CYCLES clock cycles, so its period is 2*HB_HALF_CYCLES cycles. The default gives 500 ms at 125 MHz.
- R7: Buttons pass through a two-stage synchronizer and a debouncer. A low pulse shorter than DEB_CYCLES synchronized cycles is ignored.
- R8: The higher-voltage rail (hi_*) accepts codes 0 and 10 to 15. The lower-voltage rail (lo_*) accepts codes 0 to 9. Any other code is applied and sets that rail's range-warning flag. A code in range clears the flag.
- R9: The shared table is granted to at most one rail per cycle, in round-robin order. When both rails detect a press in the same cycle, both are applied, on consecutive cycles, within two cycles of detection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_sw | input | 4 | Code switches, higher-voltage rail (bit 0 = switch 1) |
| hi_btn_n | input | 1 | Apply button, higher-voltage rail, active low |
| lo_sw | input | 4 | Code switches, lower-voltage rail |
| lo_btn_n | input | 1 | Apply button, lower-voltage rail, active low |
| hi_en | output | 1 | Supply enable, higher-voltage rail |
| hi_led | output | 1 | Status LED, higher-voltage rail |
| hi_target | output | 11 | Trim target word, higher-voltage rail |
| hi_range_warn | output | 1 | Out-of-range code applied, higher-voltage rail |
| lo_en | output | 1 | Supply enable, lower-voltage rail |
| lo_led | output | 1 | Status LED, lower-voltage rail |
| lo_target | output | 11 | Trim target word, lower-voltage rail |
| lo_range_warn | output | 1 | Out-of-range code applied, lower-voltage rail |
| heartbeat | output | 1 | Heartbeat blink output |

## Verification
A wrong latched code or a wrong table entry shows on the rail's target word and warning flag two cycles after the press is detected. The bench sees it before the button is released.

A corrupted arbiter pointer or a lost pending request shows in the simultaneous-press test. Either one rail never updates, or the two updates do not land exactly one cycle apart.

A debouncer that counts wrong shows up in two ways. A short glitch may change a rail's outputs when it should not, or a release may latch a code. An error in the heartbeat counter shows as a wrong toggle spacing within one period.

// File: rtl/vid_trim_pkg.sv
package vid_trim_pkg;
  localparam int CODE_W = 4;
  localparam int TGT_W  = 11;
  localparam int NUM_CH = 2;

  // Shared code-to-target table (trim ADC target word per code)
  function automatic logic [TGT_W-1:0] vid_target(input logic [CODE_W-1:0] c);
    logic [TGT_W-1:0] t;
    case (c)
      4'd0:  t = 11'd0;
      4'd1:  t = 11'd570;
      4'd2:  t = 11'd580;
      4'd3:  t = 11'd590;
      4'd4:  t = 11'd595;
      4'd5:  t = 11'd600;
      4'd6:  t = 11'd605;
      4'd7:  t = 11'd610;
      4'd8:  t = 11'd620;
      4'd9:  t = 11'd630;
      4'd10: t = 11'd1200;
      4'd11: t = 11'd1225;
      4'd12: t = 11'd1250;
      4'd13: t = 11'd1275;
      4'd14: t = 11'd1300;
      default: t = 11'd1310;
    endcase
    return t;
  endfunction

  // Usable code range per rail; zero (shutdown) is valid on both
  function automatic logic code_in_range(input logic hi_rail, input logic [CODE_W-1:0] c);
    if (c == '0) return 1'b1;
    if (hi_rail) return (c >= 4'd10);
    return (c <= 4'd9);
  endfunction
endpackage

// File: rtl/vid_btn_cond.sv
module vid_btn_cond #(
  parameter int DEB_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_n,
  output logic press
);
  localparam int CW = $clog2(DEB_CYCLES + 1);

  logic [1:0]    sync_q;
  logic          deb_q;
  logic [CW-1:0] cnt_q;
  logic          settle;

  assign settle = (cnt_q == CW'(DEB_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      deb_q  <= 1'b1;
      cnt_q  <= '0;
      press  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], btn_n};
      press  <= 1'b0;
      if (sync_q[1] == deb_q) begin
        cnt_q <= '0;
      end else if (settle) begin
        deb_q <= sync_q[1];
        cnt_q <= '0;
        press <= deb_q & ~sync_q[1];
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R7: a detected press is a single-cycle pulse
  assert_press_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    press |=> !press);
  // R4: a press only follows the debounced level going low
  assert_press_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    press |-> !deb_q);
endmodule

// File: rtl/vid_rr_arb.sv
module vid_rr_arb #(
  parameter int N = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [(N>1 ? $clog2(N) : 1)-1:0] gnt_idx
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] last_q;
  logic          any_gnt;

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    any_gnt = 1'b0;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (int'(last_q) + k) % N;
      if (!any_gnt && req[idx]) begin
        gnt[idx] = 1'b1;
        gnt_idx  = IW'(idx);
        any_gnt  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= IW'(N - 1);
    else if (any_gnt) last_q <= gnt_idx;
  end

  // R9: one table access per cycle, only to a requester
  assert_grant_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  assert_grant_has_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);
  assert_grant_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |-> (gnt != '0));
endmodule

// File: rtl/vid_chan.sv
module vid_chan
  import vid_trim_pkg::*;
#(
  parameter bit HI_RAIL = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              press,
  input  logic [CODE_W-1:0] sw,
  input  logic              gnt,
  input  logic [TGT_W-1:0]  tbl_target,
  output logic              req,
  output logic [CODE_W-1:0] code_q,
  output logic              en,
  output logic [TGT_W-1:0]  target,
  output logic              warn
);
  logic       pend_q;
  logic [1:0] wait_q;

  assign req = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      code_q <= '0;
      en     <= 1'b0;
      target <= '0;
      warn   <= 1'b0;
      wait_q <= '0;
    end else begin
      if (gnt) begin
        en     <= (code_q != '0);
        target <= tbl_target;
        warn   <= ~code_in_range(HI_RAIL, code_q);
      end
      if (press) begin
        code_q <= sw;
        pend_q <= 1'b1;
      end else if (gnt) begin
        pend_q <= 1'b0;
      end
      if (pend_q && !gnt) wait_q <= wait_q + 1'b1;
      else wait_q <= '0;
    end
  end

  // R1: enable and target agree (table holds zero only for code 0)
  assert_en_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
    en == (target != '0));
  // R9: a pending request waits at most one cycle for the table
  assert_wait_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wait_q <= 2'd1);
  // R4: outputs move only after a grant
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(gnt) |-> $stable(target));
endmodule

// File: rtl/vid_trim_ctrl.sv
module vid_trim_ctrl
  import vid_trim_pkg::*;
#(
  parameter int DEB_CYCLES     = 1_250_000,
  parameter int HB_HALF_CYCLES = 31_250_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  hi_sw,
  input  logic        hi_btn_n,
  input  logic [3:0]  lo_sw,
  input  logic        lo_btn_n,
  output logic        hi_en,
  output logic        hi_led,
  output logic [10:0] hi_target,
  output logic        hi_range_warn,
  output logic        lo_en,
  output logic        lo_led,
  output logic [10:0] lo_target,
  output logic        lo_range_warn,
  output logic        heartbeat
);
  localparam int IW  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int HBW = $clog2(HB_HALF_CYCLES + 1);

  logic [CODE_W-1:0] sw_a   [NUM_CH];
  logic              btn_a  [NUM_CH];
  logic              press_a[NUM_CH];
  logic [CODE_W-1:0] code_a [NUM_CH];
  logic              en_a   [NUM_CH];
  logic [TGT_W-1:0]  tgt_a  [NUM_CH];
  logic              warn_a [NUM_CH];
  logic [NUM_CH-1:0] req, gnt;
  logic [IW-1:0]     gnt_idx;
  logic [TGT_W-1:0]  tbl_target;

  // channel 0 = higher-voltage rail, channel 1 = lower-voltage rail
  assign sw_a[0]  = hi_sw;
  assign btn_a[0] = hi_btn_n;
  assign sw_a[1]  = lo_sw;
  assign btn_a[1] = lo_btn_n;

  // single shared table, addressed by the granted channel's code
  assign tbl_target = vid_target(code_a[gnt_idx]);

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_ch
      vid_btn_cond #(.DEB_CYCLES(DEB_CYCLES)) u_btn (
        .clk(clk), .rst_n(rst_n), .btn_n(btn_a[g]), .press(press_a[g]));
      vid_chan #(.HI_RAIL(g == 0)) u_chan (
        .clk(clk), .rst_n(rst_n), .press(press_a[g]), .sw(sw_a[g]),
        .gnt(gnt[g]), .tbl_target(tbl_target), .req(req[g]),
        .code_q(code_a[g]), .en(en_a[g]), .target(tgt_a[g]), .warn(warn_a[g]));
    end
  endgenerate

  vid_rr_arb #(.N(NUM_CH)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt), .gnt_idx(gnt_idx));

  assign hi_en         = en_a[0];
  assign hi_led        = en_a[0];
  assign hi_target     = tgt_a[0];
  assign hi_range_warn = warn_a[0];
  assign lo_en         = en_a[1];
  assign lo_led        = en_a[1];
  assign lo_target     = tgt_a[1];
  assign lo_range_warn = warn_a[1];

  logic [HBW-1:0] hb_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hb_cnt_q  <= '0;
      heartbeat <= 1'b0;
    end else if (hb_cnt_q == HBW'(HB_HALF_CYCLES - 1)) begin
      hb_cnt_q  <= '0;
      heartbeat <= ~heartbeat;
    end else begin
      hb_cnt_q <= hb_cnt_q + 1'b1;
    end
  end

  generate
    if (HB_HALF_CYCLES > 1) begin : g_hb_chk
      // R6: after a toggle the heartbeat holds for at least one more cycle
      assert_hb_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (heartbeat != $past(heartbeat)) |=> $stable(heartbeat));
    end
  endgenerate
endmodule

// File: tb/vid_trim_ctrl_tb.sv
module vid_trim_ctrl_tb_top;
  localparam int DEB = 8;
  localparam int HB  = 50;

  typedef struct packed {
    logic        en;
    logic [10:0] tgt;
    logic        warn;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] hi_sw = 4'd0, lo_sw = 4'd0;
  logic hi_btn_n = 1'b1, lo_btn_n = 1'b1;
  logic hi_en, hi_led, hi_range_warn, lo_en, lo_led, lo_range_warn, heartbeat;
  logic [10:0] hi_target, lo_target;

  always #4 clk = ~clk;

  vid_trim_ctrl #(.DEB_CYCLES(DEB), .HB_HALF_CYCLES(HB)) dut_i (
    .clk(clk), .rst_n(rst_n), .hi_sw(hi_sw), .hi_btn_n(hi_btn_n),
    .lo_sw(lo_sw), .lo_btn_n(lo_btn_n), .hi_en(hi_en), .hi_led(hi_led),
    .hi_target(hi_target), .hi_range_warn(hi_range_warn), .lo_en(lo_en),
    .lo_led(lo_led), .lo_target(lo_target), .lo_range_warn(lo_range_warn),
    .heartbeat(heartbeat));

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit mon_on = 1'b0, done = 1'b0;
  exp_t hi_q[$], lo_q[$];
  exp_t prev_hi = '0, prev_lo = '0, last_hi = '0, last_lo = '0;
  int hi_chg = 0, lo_chg = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, expv);
    end
  endtask

  function automatic logic [10:0] ref_tgt(input logic [3:0] c);
    int lo_steps[10] = '{0, 570, 580, 590, 595, 600, 605, 610, 620, 630};
    if (c <= 4'd9) return 11'(lo_steps[c]);
    if (c == 4'd15) return 11'd1310;
    return 11'(1200 + 25 * (int'(c) - 10));
  endfunction

  function automatic exp_t ref_out(input bit hi, input logic [3:0] c);
    exp_t e;
    e.en   = (c != 0);
    e.tgt  = ref_tgt(c);
    e.warn = hi ? (c >= 1 && c <= 9) : (c >= 10);
    return e;
  endfunction

  // monitor: pops expected items as the outputs change
  always @(negedge clk) begin
    if (mon_on) begin
      exp_t cur_h, cur_l, e;
      cur_h = '{hi_en, hi_target, hi_range_warn};
      cur_l = '{lo_en, lo_target, lo_range_warn};
      if (cur_h != prev_hi) begin
        hi_chg = cyc;
        if (hi_q.size() == 0) chk(0, "R4", "unexpected hi change", int'(cur_h), int'(prev_hi));
        else begin
          e = hi_q.pop_front();
          chk(cur_h == e, "R2", "hi scoreboard item", int'(cur_h), int'(e));
        end
        prev_hi = cur_h;
      end
      if (cur_l != prev_lo) begin
        lo_chg = cyc;
        if (lo_q.size() == 0) chk(0, "R4", "unexpected lo change", int'(cur_l), int'(prev_lo));
        else begin
          e = lo_q.pop_front();
          chk(cur_l == e, "R2", "lo scoreboard item", int'(cur_l), int'(e));
        end
        prev_lo = cur_l;
      end
      if (hi_led != hi_en) chk(0, "R1", "hi led vs en", int'(hi_led), int'(hi_en));
      if (lo_led != lo_en) chk(0, "R1", "lo led vs en", int'(lo_led), int'(lo_en));
    end
  end

  task automatic press(input bit hi, input bit lo);
    @(negedge clk);
    if (hi) hi_btn_n = 1'b0;
    if (lo) lo_btn_n = 1'b0;
    repeat (DEB + 6) @(negedge clk);
    hi_btn_n = 1'b1;
    lo_btn_n = 1'b1;
    repeat (DEB + 8) @(negedge clk);
  endtask

  task automatic final_state(input string rq);
    exp_t ch, cl;
    ch = '{hi_en, hi_target, hi_range_warn};
    cl = '{lo_en, lo_target, lo_range_warn};
    chk(hi_q.size() == 0 && lo_q.size() == 0, rq, "items left in queue",
        hi_q.size() + lo_q.size(), 0);
    chk(ch == last_hi, rq, "hi outputs", int'(ch), int'(last_hi));
    chk(cl == last_lo, rq, "lo outputs", int'(cl), int'(last_lo));
  endtask

  // driver: push expected item, apply code with a press
  task automatic apply(input bit hi, input logic [3:0] c, input string rq);
    exp_t e;
    e = ref_out(hi, c);
    if (hi) begin
      if (e != last_hi) hi_q.push_back(e);
      last_hi = e;
      hi_sw = c;
    end else begin
      if (e != last_lo) lo_q.push_back(e);
      last_lo = e;
      lo_sw = c;
    end
    press(hi, !hi);
    final_state(rq);
  endtask

  initial begin : main
    repeat (3) @(negedge clk);
    // R5: reset state
    chk(hi_en == 0 && hi_led == 0, "R5", "hi en/led", int'({hi_en, hi_led}), 0);
    chk(lo_en == 0 && lo_led == 0, "R5", "lo en/led", int'({lo_en, lo_led}), 0);
    chk(hi_target == 0 && lo_target == 0, "R5", "targets", int'(hi_target | lo_target), 0);
    chk(hi_range_warn == 0 && lo_range_warn == 0, "R5", "warns", 0, 0);
    chk(heartbeat == 0, "R5", "heartbeat", int'(heartbeat), 0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    repeat (2) @(negedge clk);

    apply(1, 4'd12, "R2");
    apply(1, 4'd15, "R2");
    apply(1, 4'd10, "R2");
    apply(1, 4'd3,  "R8");   // below hi range: warn
    apply(1, 4'd0,  "R1");   // shutdown
    apply(1, 4'd13, "R1");
    apply(0, 4'd5,  "R2");
    apply(0, 4'd9,  "R2");
    apply(0, 4'd8,  "R3");   // sw=1000 -> code 8, target 620
    apply(0, 4'd1,  "R3");
    apply(0, 4'd12, "R8");   // above lo range: warn, same target as hi rail
    apply(0, 4'd0,  "R1");
    apply(0, 4'd7,  "R8");   // back in range clears warn

    // R4: switches change, no press
    hi_sw = 4'd11; lo_sw = 4'd2;
    repeat (40) @(negedge clk);
    final_state("R4");

    // R4: release edge latches nothing
    hi_sw = 4'd14;
    last_hi = ref_out(1, 4'd14);
    hi_q.push_back(last_hi);
    @(negedge clk) hi_btn_n = 1'b0;
    repeat (DEB + 6) @(negedge clk);
    hi_sw = 4'd11;
    @(negedge clk) hi_btn_n = 1'b1;
    repeat (DEB + 8) @(negedge clk);
    final_state("R4");

    // R7: short glitch ignored
    lo_sw = 4'd4;
    @(negedge clk) lo_btn_n = 1'b0;
    repeat (3) @(negedge clk);
    lo_btn_n = 1'b1;
    repeat (DEB + 8) @(negedge clk);
    final_state("R7");

    // R9: simultaneous presses, applied on consecutive cycles
    hi_sw = 4'd11; lo_sw = 4'd6;
    last_hi = ref_out(1, 4'd11); hi_q.push_back(last_hi);
    last_lo = ref_out(0, 4'd6);  lo_q.push_back(last_lo);
    press(1, 1);
    final_state("R9");
    chk((hi_chg - lo_chg == 1) || (lo_chg - hi_chg == 1), "R9",
        "update spacing", hi_chg - lo_chg, 1);

    // R6: heartbeat spacing
    begin
      int t0, t1;
      logic hb0;
      hb0 = heartbeat;
      while (heartbeat == hb0) @(negedge clk);
      t0 = cyc;
      hb0 = heartbeat;
      while (heartbeat == hb0) @(negedge clk);
      t1 = cyc;
      chk(t1 - t0 == HB, "R6", "toggle spacing", t1 - t0, HB);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(0, "R5", "watchdog expired", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule